// File: doc/BRIEF.md
# Operand-Routed ALU with Output Shifter

This block is a registered arithmetic/logic datapath of configurable width. Two register values, X and Y, arrive on input ports. A routing stage chooses which of them, or a forced zero, feeds each side of a combinational arithmetic/logic stage. Its result then passes through a one-position shifter and is captured in the result register Z, together with four status flags. It is meant to sit under a sequencer that drives its control fields directly every cycle.

Control is split into three independent fields: a 2-bit source select, a 3-bit operation code and a 2-bit shift mode. A carry input is also provided. The block carries no data stream, so it has no valid/ready handshake. A store request is the only timing control, and it takes effect on the next rising clock edge. The sequencer must therefore hold the fields stable from one edge to the next. No back-pressure exists: every accepted store completes in exactly one cycle.

Top module: `alu_shift_dp`

## Requirements
- R1: Source select (MSB first) routes operands (first, second) as follows: 00 gives (X, Y), 01 gives (X, 0), 10 gives (Y, 0) and 11 gives (Y, X).
- R2: Operation 000 produces first + second + carry-in, modulo 2^WIDTH.
- R3: Operation 001 produces first − second − (1 − carry-in). Operation 010 produces second − first − (1 − carry-in). Both are formed by adding the inverted subtrahend and the carry-in.
- R4: The logic operations are: 011 AND, 100 OR, 101 XOR, 110 (NOT first) AND second, and 111 (NOT first) OR second.
- R5: Shift mode (MSB first) 00 stores the result unchanged. 10 stores it shifted left by one with a zero fill. 01 stores an arithmetic right shift by one, which copies the top bit.
- R6: Shift mode 11 leaves Z and all four flags unchanged even while a store is requested.
- R7: While the store request is low, Z and the flags hold their values whatever the other inputs do.
- R8: On a store, the zero flag is set exactly when the value written to Z is all zeros. The sign flag equals that value's top bit.
- R9: For operations 000 to 010, carry-out is the adder's carry from the top bit (1 means no borrow for subtractions). Overflow is the XOR of the carry into and the carry out of the top bit, so it marks a signed result out of range. For operations 011 to 111, both flags are written as 0. Both flags describe the unshifted result.
- R10: An active-low asynchronous reset clears Z and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_i | input | WIDTH | Operand register X |
| y_i | input | WIDTH | Operand register Y |
| src_sel_i | input | 2 | Operand routing select |
| op_sel_i | input | 3 | Operation code |
| shf_sel_i | input | 2 | Output shift mode |
| cin_i | input | 1 | Carry input (borrow is its inverse) |
| store_i | input | 1 | Store request for the next edge |
| z_o | output | WIDTH | Result register Z |
| flag_zero_o | output | 1 | Stored value is zero |
| flag_sign_o | output | 1 | Top bit of stored value |
| flag_ovf_o | output | 1 | Signed overflow of last arithmetic store |
| flag_carry_o | output | 1 | Carry-out of last arithmetic store |

## Verification
The assertions assume that every control field, operand and the store request is settled before each rising edge. They also assume that all select codes are two-state values. The bench meets both conditions by changing inputs only on falling edges and by always driving defined codes. The flag assertions check the cycle after a store request only when the shift mode is not 11, because the block defines that mode as a hold. The bench therefore covers the hold mode with its own directed checks of Z and the flags at the ports.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

  typedef enum logic [1:0] {
    SRC_XY = 2'b00,
    SRC_X0 = 2'b01,
    SRC_Y0 = 2'b10,
    SRC_YX = 2'b11
  } src_e;

  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_SUBAB = 3'b001,
    OP_SUBBA = 3'b010,
    OP_AND   = 3'b011,
    OP_OR    = 3'b100,
    OP_XOR   = 3'b101,
    OP_ANDN  = 3'b110,
    OP_ORN   = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    SH_PASS = 2'b00,
    SH_ASR  = 2'b01,
    SH_SHL  = 2'b10,
    SH_KEEP = 2'b11
  } shf_e;

  localparam int OP_LOGIC_FIRST = 3;

endpackage

// File: rtl/alu_src_mux.sv
module alu_src_mux
  import alu_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  src_e             sel_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o
);

  always_comb begin
    unique case (sel_i)
      SRC_XY: begin a_o = x_i; b_o = y_i;        end
      SRC_X0: begin a_o = x_i; b_o = '0;         end
      SRC_Y0: begin a_o = y_i; b_o = '0;         end
      default: begin a_o = y_i; b_o = x_i;       end
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  op_e              op_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] r_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int LOW = WIDTH - 1;

  logic [WIDTH-1:0] p, q, logic_r;
  logic [WIDTH:0]   sum_full;
  logic [LOW:0]     sum_low;
  logic             is_arith;
  logic             carry_into_msb;

  // Subtraction: add the inverted subtrahend; carry-in of 1 means no borrow.
  always_comb begin
    unique case (op_i)
      OP_SUBAB: begin p = a_i; q = ~b_i; end
      OP_SUBBA: begin p = b_i; q = ~a_i; end
      default:  begin p = a_i; q = b_i;  end
    endcase
  end

  assign sum_full       = {1'b0, p} + {1'b0, q} + {{WIDTH{1'b0}}, cin_i};
  assign sum_low        = {1'b0, p[LOW-1:0]} + {1'b0, q[LOW-1:0]} + {{LOW{1'b0}}, cin_i};
  assign carry_into_msb = sum_low[LOW];
  assign is_arith       = (op_i == OP_ADD) || (op_i == OP_SUBAB) || (op_i == OP_SUBBA);

  always_comb begin
    unique case (op_i)
      OP_AND:  logic_r = a_i & b_i;
      OP_OR:   logic_r = a_i | b_i;
      OP_XOR:  logic_r = a_i ^ b_i;
      OP_ANDN: logic_r = ~a_i & b_i;
      OP_ORN:  logic_r = ~a_i | b_i;
      default: logic_r = '0;
    endcase
  end

  assign r_o    = is_arith ? sum_full[WIDTH-1:0] : logic_r;
  assign cout_o = is_arith & sum_full[WIDTH];
  assign ovf_o  = is_arith & (carry_into_msb ^ sum_full[WIDTH]);

endmodule

// File: rtl/alu_out_shift.sv
module alu_out_shift
  import alu_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] r_i,
  input  shf_e             mode_i,
  output logic [WIDTH-1:0] s_o
);

  always_comb begin
    unique case (mode_i)
      SH_ASR:  s_o = {r_i[WIDTH-1], r_i[WIDTH-1:1]};
      SH_SHL:  s_o = {r_i[WIDTH-2:0], 1'b0};
      default: s_o = r_i;
    endcase
  end

endmodule

// File: rtl/alu_shift_dp.sv
module alu_shift_dp
  import alu_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [1:0]       src_sel_i,
  input  logic [2:0]       op_sel_i,
  input  logic [1:0]       shf_sel_i,
  input  logic             cin_i,
  input  logic             store_i,
  output logic [WIDTH-1:0] z_o,
  output logic             flag_zero_o,
  output logic             flag_sign_o,
  output logic             flag_ovf_o,
  output logic             flag_carry_o
);

  logic [WIDTH-1:0] opnd_a, opnd_b, alu_r, shifted;
  logic             alu_cout, alu_ovf, write_en;

  alu_src_mux #(.WIDTH(WIDTH)) u_mux (
    .x_i   (x_i),
    .y_i   (y_i),
    .sel_i (src_e'(src_sel_i)),
    .a_o   (opnd_a),
    .b_o   (opnd_b)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .op_i   (op_e'(op_sel_i)),
    .cin_i  (cin_i),
    .r_o    (alu_r),
    .cout_o (alu_cout),
    .ovf_o  (alu_ovf)
  );

  alu_out_shift #(.WIDTH(WIDTH)) u_shift (
    .r_i    (alu_r),
    .mode_i (shf_e'(shf_sel_i)),
    .s_o    (shifted)
  );

  assign write_en = store_i && (shf_e'(shf_sel_i) != SH_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_o          <= '0;
      flag_zero_o  <= 1'b0;
      flag_sign_o  <= 1'b0;
      flag_ovf_o   <= 1'b0;
      flag_carry_o <= 1'b0;
    end else if (write_en) begin
      z_o          <= shifted;
      flag_zero_o  <= (shifted == '0);
      flag_sign_o  <= shifted[WIDTH-1];
      flag_ovf_o   <= alu_ovf;
      flag_carry_o <= alu_cout;
    end
  end

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !store_i |=> ($stable(z_o) && $stable(flag_carry_o) && $stable(flag_ovf_o)));

  assert_keep_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && shf_sel_i == 2'b11) |=> ($stable(z_o) && $stable(flag_zero_o) && $stable(flag_sign_o)));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && shf_sel_i != 2'b11) |=> (flag_zero_o == (z_o == '0)));

  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && shf_sel_i != 2'b11) |=> (flag_sign_o == z_o[WIDTH-1]));

  assert_logic_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && shf_sel_i != 2'b11 && int'(op_sel_i) >= OP_LOGIC_FIRST)
      |=> (!flag_carry_o && !flag_ovf_o));

endmodule

// File: tb/alu_shift_dp_bench.sv
module alu_shift_dp_bench;

  localparam int W = 4;
  localparam int M = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] x_i = '0, y_i = '0;
  logic [1:0]   src_sel_i = '0, shf_sel_i = '0;
  logic [2:0]   op_sel_i = '0;
  logic         cin_i = 1'b0, store_i = 1'b0;
  logic [W-1:0] z_o;
  logic         flag_zero_o, flag_sign_o, flag_ovf_o, flag_carry_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  alu_shift_dp #(.WIDTH(W)) u_alu_shift_dp (
    .clk, .rst_n, .x_i, .y_i, .src_sel_i, .op_sel_i, .shf_sel_i,
    .cin_i, .store_i, .z_o, .flag_zero_o, .flag_sign_o, .flag_ovf_o, .flag_carry_o
  );

  function automatic int sgn(input int v);
    return (v >= HALF) ? v - (M + 1) : v;
  endfunction

  function automatic void model(input int x, y, src, op, cin, shf,
                                output int z, zf, sf, cf, vf);
    int a, b, r, t, ts;
    case (src)
      0: begin a = x; b = y; end
      1: begin a = x; b = 0; end
      2: begin a = y; b = 0; end
      default: begin a = y; b = x; end
    endcase
    cf = 0; vf = 0; r = 0;
    case (op)
      0: begin t = a + b + cin; r = t & M; cf = int'(t > M);
               ts = sgn(a) + sgn(b) + cin; vf = int'(ts >= HALF || ts < -HALF); end
      1: begin t = a - b - (1 - cin); r = t & M; cf = int'(t >= 0);
               ts = sgn(a) - sgn(b) - (1 - cin); vf = int'(ts >= HALF || ts < -HALF); end
      2: begin t = b - a - (1 - cin); r = t & M; cf = int'(t >= 0);
               ts = sgn(b) - sgn(a) - (1 - cin); vf = int'(ts >= HALF || ts < -HALF); end
      3: r = a & b;
      4: r = a | b;
      5: r = a ^ b;
      6: r = (~a & M) & b;
      default: r = ((~a) | b) & M;
    endcase
    if (shf == 1) r = (r >> 1) | (r & HALF);
    else if (shf == 2) r = (r << 1) & M;
    z = r; zf = int'(r == 0); sf = (r >> (W - 1)) & 1;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input int x, y, src, op, cin, shf, st);
    x_i = W'(x); y_i = W'(y); src_sel_i = 2'(src); op_sel_i = 3'(op);
    cin_i = 1'(cin); shf_sel_i = 2'(shf); store_i = 1'(st);
    @(negedge clk);
  endtask

  task automatic store_and_check(input string tag, input int x, y, src, op, cin, shf);
    int z, zf, sf, cf, vf;
    model(x, y, src, op, cin, shf, z, zf, sf, cf, vf);
    apply(x, y, src, op, cin, shf, 1);
    check(tag, "z", int'(z_o), z);
    check("R8", "zero/sign", int'({flag_zero_o, flag_sign_o}), zf * 2 + sf);
    check("R9", "ovf/carry", int'({flag_ovf_o, flag_carry_o}), vf * 2 + cf);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k;
    string tag;
    repeat (2) @(negedge clk);
    check("R10", "z after reset", int'(z_o), 0);
    check("R10", "flags after reset",
          int'({flag_zero_o, flag_sign_o, flag_ovf_o, flag_carry_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 routing: pass-through via add with zero second operand, and swapped subtract
    store_and_check("R1", 9, 3, 1, 0, 0, 0);    // X + 0
    store_and_check("R1", 9, 3, 2, 0, 0, 0);    // Y + 0
    store_and_check("R1", 9, 3, 3, 2, 1, 0);    // X - Y with (Y,X) routing
    store_and_check("R1", 5, 12, 0, 1, 1, 0);   // X - Y with (X,Y) routing
    // Y - X borrow-free: sign reports X > Y
    store_and_check("R3", 7, 2, 0, 2, 1, 0);
    check("R3", "sign for X>Y", int'(flag_sign_o), 1);
    // complement of Y shifted left
    store_and_check("R5", 0, 6, 2, 7, 0, 2);
    check("R4", "~Y<<1", int'(z_o), ((~6) << 1) & M);

    // R6: keep mode holds Z and flags
    store_and_check("R6", 0, 3, 2, 0, 0, 0);
    apply(15, 15, 0, 0, 1, 3, 1);
    check("R6", "z held", int'(z_o), 3);
    check("R6", "flags held", int'({flag_zero_o, flag_sign_o, flag_ovf_o, flag_carry_o}), 0);
    // R7: no store holds Z and flags
    store_and_check("R7", 8, 8, 0, 0, 0, 0);    // carry and overflow set, Z=0
    apply(1, 2, 0, 4, 0, 0, 0);
    check("R7", "z held", int'(z_o), 0);
    check("R7", "flags held", int'({flag_zero_o, flag_sign_o, flag_ovf_o, flag_carry_o}), 4'b1011);

    // Sweep: every operand pair, operation and carry-in; routing and shift rotate
    k = 0;
    for (int x = 0; x <= M; x++)
      for (int y = 0; y <= M; y++)
        for (int op = 0; op < 8; op++)
          for (int c = 0; c < 2; c++) begin
            int src = k % 4;
            int shf = (k / 4) % 3;
            if (shf != 0) tag = "R5";
            else if (op == 0) tag = "R2";
            else if (op < 3) tag = "R3";
            else tag = "R4";
            store_and_check(tag, x, y, src, op, c, shf);
            k++;
          end

    store_i = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule